// File: doc/BRIEF.md
# Speculation Check and Recovery-Branch Unit

This block resolves a speculation-check operation in one cycle. It can check a register in two ways. A control-mode check looks at the deferred-exception flag of the source register. For a general register this is the NaT bit. For a floating-point register it is the NaTVal encoding. A data-mode check looks up a small, fully associative table of outstanding advanced loads. The lookup key is the register-file select and the register number. The check also fails for the hard-wired registers and whenever a configuration input forces data-mode failures.

When a check fails, the unit recovers in one of two ways:
- If branching is enabled, it takes a branch to a 16-byte bundle address. The address is the bundle-aligned IP plus the signed 21-bit displacement shifted left by four.
- If branching is disabled, it raises a speculative-operation fault. The fault carries the zero-extended displacement as the interruption immediate.

A successful data-mode check with the clear completer invalidates the matching table entries. Advanced loads fill the table through an insert port, which overwrites entries round-robin.

The operation input is a valid/ready stream. `op_ready` is low during reset and for the first cycle after it, and then stays high. The unit therefore never applies back-pressure, and a new operation may be presented every cycle. Results are not held: each result is a one-cycle pulse on `done` with its fields.

Top module: `spec_check_unit`

## Requirements
- R1: Control mode (`op_data_mode`=0) with `op_fp`=0 fails exactly when `src_nat`=1. `src_natval` is ignored in this case.
- R2: Control mode with `op_fp`=1 fails exactly when `src_natval`=1. `src_nat` is ignored in this case.
- R3: Data mode (`op_data_mode`=1) fails when no valid table entry has both the same `op_fp` and the same `op_reg`.
- R4: A data-mode check on a general register numbered 0, or on a floating-point register numbered 0 or 1, always fails, even if a matching entry exists.
- R5: When `cfg_force_fail`=1, every data-mode check fails even if an entry matches. This input has no effect on control-mode checks.
- R6: When a check fails and `cfg_branch_en`=1, `br_taken`=1 and `fault`=0. In that case `br_target` = (`op_ip` with bits 3:0 cleared) + (sign-extended `op_imm` << 4).
- R7: When a check fails and `cfg_branch_en`=0, `fault`=1 and `br_taken`=0. In that case `fault_imm` = `op_imm` zero-extended to 64 bits.
- R8: A successful data-mode check with `op_clr`=1 pulses `inv_valid` and reports the key on `inv_fp`/`inv_reg`. It also clears every matching entry, so a later identical check fails. With `op_clr`=0 the entry stays valid.
- R9: A failing data-mode check with `op_clr`=1 invalidates nothing. This includes checks that fail because of `cfg_force_fail`. `inv_valid` stays 0 and the entry still matches afterwards.
- R10: With `op_qp`=0 the operation has no effect. `done` still pulses, and `chk_fail`, `br_taken`, `fault` and `inv_valid` are all 0. The table is left unchanged.
- R11: Results appear on the clock edge after an operation is accepted (`op_valid` and `op_ready` both high). `done` is high for exactly that one cycle per accepted operation.
- R12: The table holds 8 entries. Each insert writes the next slot in round-robin order, so the ninth insert replaces the first entry written.
- R13: After reset all outputs are 0 and the table is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present |
| op_ready | output | 1 | Operation accepted when high |
| op_data_mode | input | 1 | 0 = control (deferred-exception flag) check, 1 = data (table) check |
| op_fp | input | 1 | Register-file select: 0 = general, 1 = floating-point |
| op_reg | input | 7 | Register number |
| op_clr | input | 1 | Clear completer: 1 = invalidate the matching entry on success |
| op_qp | input | 1 | Qualifying predicate |
| src_nat | input | 1 | NaT bit of the source general register |
| src_natval | input | 1 | Source floating-point register holds NaTVal |
| op_ip | input | 64 | Address of the current bundle |
| op_imm | input | 21 | Signed bundle displacement |
| cfg_branch_en | input | 1 | 1 = branch on failure, 0 = raise a fault instead |
| cfg_force_fail | input | 1 | Force every data-mode check to fail |
| ins_valid | input | 1 | Insert an advanced-load entry |
| ins_fp | input | 1 | Register-file select of the inserted entry |
| ins_reg | input | 7 | Register number of the inserted entry |
| done | output | 1 | One-cycle completion pulse |
| chk_fail | output | 1 | The completed check failed |
| br_taken | output | 1 | Recovery branch taken |
| br_target | output | 64 | Recovery branch address |
| fault | output | 1 | Speculative-operation fault raised |
| fault_imm | output | 64 | Interruption immediate (zero-extended displacement) |
| inv_valid | output | 1 | A table invalidation was performed |
| inv_fp | output | 1 | Register-file select of the invalidated key |
| inv_reg | output | 7 | Register number of the invalidated key |

## Verification
The hardest state to reach from the ports is a table holding a live entry when that entry's check fails for another reason. Two cases matter: a hard-wired register number, and the force-fail configuration. Only in these cases does the no-invalidate-on-failure rule show up, and it can only be seen through a later successful check. The bench gets there with directed sequences: insert, then a clear-completer check under the failing condition, then a plain check of the same key. It also keeps a round-robin model of the table. This lets the random stimulus hit an entry often: register numbers come from a small pool, and inserts are interleaved with checks.

// File: rtl/spec_chk_pkg.sv
package spec_chk_pkg;
  localparam int REG_W = 7;

  typedef struct packed {
    logic             fp;
    logic [REG_W-1:0] num;
  } reg_key_t;

  typedef enum logic {
    MODE_CTRL = 1'b0,
    MODE_DATA = 1'b1
  } chk_mode_e;
endpackage

// File: rtl/spec_addr_table.sv
module spec_addr_table
  import spec_chk_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ins_valid,
  input  reg_key_t ins_key,
  input  reg_key_t look_key,
  input  logic     inv_en,
  output logic     hit
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] vld;
  reg_key_t         keys [DEPTH];
  logic [IDX_W-1:0] wr_ptr;
  logic [DEPTH-1:0] match;

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_cmp
      assign match[gi] = vld[gi] && (keys[gi] == look_key);
    end
  endgenerate

  assign hit = |match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld    <= '0;
      wr_ptr <= '0;
      for (int i = 0; i < DEPTH; i++) keys[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (ins_valid && (wr_ptr == IDX_W'(i))) begin
          vld[i]  <= 1'b1;
          keys[i] <= ins_key;
        end else if (inv_en && match[i]) begin
          vld[i] <= 1'b0;
        end
      end
      if (ins_valid) begin
        if (wr_ptr == IDX_W'(DEPTH - 1)) wr_ptr <= '0;
        else                             wr_ptr <= wr_ptr + 1'b1;
      end
    end
  end

  a_r12_slot_filled: assert property (@(posedge clk) disable iff (!rst_n)
    ins_valid |=> vld[$past(wr_ptr)]);

  a_r12_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ins_valid |=> $stable(wr_ptr));

  a_r8_inv_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    inv_en |-> hit);
endmodule

// File: rtl/spec_verdict.sv
module spec_verdict
  import spec_chk_pkg::*;
#(
  parameter int GR_HARD_CNT = 1,
  parameter int FP_HARD_CNT = 2
) (
  input  chk_mode_e mode,
  input  reg_key_t  key,
  input  logic      clr,
  input  logic      nat,
  input  logic      natval,
  input  logic      force_fail,
  input  logic      hit,
  output logic      fail,
  output logic      want_inv
);
  logic hard_reg;
  logic data_fail;

  always_comb begin
    if (key.fp) hard_reg = (key.num < REG_W'(FP_HARD_CNT));
    else        hard_reg = (key.num < REG_W'(GR_HARD_CNT));
  end

  assign data_fail = hard_reg || !hit || force_fail;

  always_comb begin
    if (mode == MODE_DATA) begin
      fail     = data_fail;
      want_inv = clr && !data_fail;
    end else begin
      fail     = key.fp ? natval : nat;
      want_inv = 1'b0;
    end
  end

  always_comb begin
    if (want_inv) a_r9_inv_only_on_pass: assert (!fail);
  end
endmodule

// File: rtl/spec_recover.sv
module spec_recover #(
  parameter int IP_W  = 64,
  parameter int IMM_W = 21,
  parameter int SHIFT = 4
) (
  input  logic [IP_W-1:0]  ip,
  input  logic [IMM_W-1:0] imm,
  output logic [IP_W-1:0]  target,
  output logic [IP_W-1:0]  imm_zx
);
  localparam logic [IP_W-1:0] ALIGN_MASK = ~((IP_W'(1) << SHIFT) - IP_W'(1));

  logic [IP_W-1:0] disp_sx;

  assign disp_sx = {{(IP_W-IMM_W){imm[IMM_W-1]}}, imm};
  assign target  = (ip & ALIGN_MASK) + (disp_sx << SHIFT);
  assign imm_zx  = {{(IP_W-IMM_W){1'b0}}, imm};
endmodule

// File: rtl/spec_check_unit.sv
module spec_check_unit
  import spec_chk_pkg::*;
#(
  parameter int IP_W  = 64,
  parameter int IMM_W = 21,
  parameter int SHIFT = 4,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic             op_data_mode,
  input  logic             op_fp,
  input  logic [REG_W-1:0] op_reg,
  input  logic             op_clr,
  input  logic             op_qp,
  input  logic             src_nat,
  input  logic             src_natval,
  input  logic [IP_W-1:0]  op_ip,
  input  logic [IMM_W-1:0] op_imm,
  input  logic             cfg_branch_en,
  input  logic             cfg_force_fail,
  input  logic             ins_valid,
  input  logic             ins_fp,
  input  logic [REG_W-1:0] ins_reg,
  output logic             done,
  output logic             chk_fail,
  output logic             br_taken,
  output logic [IP_W-1:0]  br_target,
  output logic             fault,
  output logic [IP_W-1:0]  fault_imm,
  output logic             inv_valid,
  output logic             inv_fp,
  output logic [REG_W-1:0] inv_reg
);
  reg_key_t        look_key;
  reg_key_t        ins_key;
  chk_mode_e       mode;
  logic            hit;
  logic            fail_c;
  logic            want_inv;
  logic            accept;
  logic            act;
  logic            inv_en;
  logic [IP_W-1:0] tgt_c;
  logic [IP_W-1:0] imm_c;
  logic            ready_q;

  assign look_key = '{fp: op_fp, num: op_reg};
  assign ins_key  = '{fp: ins_fp, num: ins_reg};
  assign mode     = chk_mode_e'(op_data_mode);
  assign op_ready = ready_q;
  assign accept   = op_valid && ready_q;
  assign act      = accept && op_qp;
  assign inv_en   = act && want_inv;

  spec_addr_table #(.DEPTH(DEPTH)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .ins_valid(ins_valid),
    .ins_key  (ins_key),
    .look_key (look_key),
    .inv_en   (inv_en),
    .hit      (hit)
  );

  spec_verdict u_verdict (
    .mode      (mode),
    .key       (look_key),
    .clr       (op_clr),
    .nat       (src_nat),
    .natval    (src_natval),
    .force_fail(cfg_force_fail),
    .hit       (hit),
    .fail      (fail_c),
    .want_inv  (want_inv)
  );

  spec_recover #(.IP_W(IP_W), .IMM_W(IMM_W), .SHIFT(SHIFT)) u_recover (
    .ip    (op_ip),
    .imm   (op_imm),
    .target(tgt_c),
    .imm_zx(imm_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q   <= 1'b0;
      done      <= 1'b0;
      chk_fail  <= 1'b0;
      br_taken  <= 1'b0;
      br_target <= '0;
      fault     <= 1'b0;
      fault_imm <= '0;
      inv_valid <= 1'b0;
      inv_fp    <= 1'b0;
      inv_reg   <= '0;
    end else begin
      ready_q   <= 1'b1;
      done      <= accept;
      chk_fail  <= act && fail_c;
      br_taken  <= act && fail_c && cfg_branch_en;
      fault     <= act && fail_c && !cfg_branch_en;
      br_target <= (act && fail_c && cfg_branch_en) ? tgt_c : '0;
      fault_imm <= (act && fail_c && !cfg_branch_en) ? imm_c : '0;
      inv_valid <= inv_en;
      inv_fp    <= inv_en ? op_fp : 1'b0;
      inv_reg   <= inv_en ? op_reg : '0;
    end
  end

  a_r11_done_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(op_valid && op_ready));

  a_r10_effects_need_done: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_fail || br_taken || fault || inv_valid) |-> done);

  a_r7_branch_fault_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(br_taken && fault));

  a_r6_target_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> (br_target[SHIFT-1:0] == '0));

  a_r9_no_inv_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
    inv_valid |-> !chk_fail);

  a_r6_fail_recovers: assert property (@(posedge clk) disable iff (!rst_n)
    chk_fail |-> (br_taken || fault));
endmodule

// File: tb/tb_spec_check_unit.sv
module tb_spec_check_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 0, op_data_mode = 0, op_fp = 0, op_clr = 0, op_qp = 0;
  logic [6:0]  op_reg = '0;
  logic        src_nat = 0, src_natval = 0;
  logic [63:0] op_ip = '0;
  logic [20:0] op_imm = '0;
  logic        cfg_branch_en = 1, cfg_force_fail = 0;
  logic        ins_valid = 0, ins_fp = 0;
  logic [6:0]  ins_reg = '0;
  logic        op_ready, done, chk_fail, br_taken, fault, inv_valid, inv_fp;
  logic [63:0] br_target, fault_imm;
  logic [6:0]  inv_reg;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic       m_vld [8];
  logic       m_fp  [8];
  logic [6:0] m_reg [8];
  int         m_ptr = 0;

  always #4 clk = ~clk;

  spec_check_unit dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_data_mode(op_data_mode), .op_fp(op_fp), .op_reg(op_reg), .op_clr(op_clr),
    .op_qp(op_qp), .src_nat(src_nat), .src_natval(src_natval), .op_ip(op_ip),
    .op_imm(op_imm), .cfg_branch_en(cfg_branch_en), .cfg_force_fail(cfg_force_fail),
    .ins_valid(ins_valid), .ins_fp(ins_fp), .ins_reg(ins_reg), .done(done),
    .chk_fail(chk_fail), .br_taken(br_taken), .br_target(br_target), .fault(fault),
    .fault_imm(fault_imm), .inv_valid(inv_valid), .inv_fp(inv_fp), .inv_reg(inv_reg)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_target(input logic [63:0] ip, input logic [20:0] imm);
    return (ip & ~64'hF) + ({{43{imm[20]}}, imm} << 4);
  endfunction

  function automatic bit model_hit(input logic fp, input logic [6:0] rn);
    for (int i = 0; i < 8; i++) if (m_vld[i] && m_fp[i] == fp && m_reg[i] == rn) return 1;
    return 0;
  endfunction

  task automatic do_ins(input logic fp, input logic [6:0] rn);
    @(negedge clk);
    ins_valid = 1; ins_fp = fp; ins_reg = rn;
    @(negedge clk);
    ins_valid = 0;
    m_vld[m_ptr] = 1; m_fp[m_ptr] = fp; m_reg[m_ptr] = rn;
    m_ptr = (m_ptr + 1) % 8;
  endtask

  // one accepted operation; outputs are checked one edge after acceptance
  task automatic do_op(input logic dm, input logic fp, input logic [6:0] rn, input logic clr,
                       input logic qp, input logic nat, input logic nv, input logic [63:0] ip,
                       input logic [20:0] imm, input string req);
    bit hard, hit, fail, inv;
    @(negedge clk);
    chk(done == 0, "R11 idle done low", {63'b0, done}, 64'd0);
    chk(op_ready == 1, "R11 ready high", {63'b0, op_ready}, 64'd1);
    op_valid = 1; op_data_mode = dm; op_fp = fp; op_reg = rn; op_clr = clr; op_qp = qp;
    src_nat = nat; src_natval = nv; op_ip = ip; op_imm = imm;
    hit  = model_hit(fp, rn);
    hard = fp ? (rn < 2) : (rn == 0);
    if (dm) fail = hard || !hit || cfg_force_fail;
    else    fail = fp ? nv : nat;
    fail = fail && qp;
    inv  = qp && dm && clr && !fail && hit && !hard && !cfg_force_fail;
    @(negedge clk);
    op_valid = 0;
    chk(done == 1, {req, " done"}, {63'b0, done}, 64'd1);
    chk(chk_fail == fail, {req, " fail"}, {63'b0, chk_fail}, {63'b0, fail});
    chk(br_taken == (fail && cfg_branch_en), {req, " R6 br_taken"}, {63'b0, br_taken},
        {63'b0, fail && cfg_branch_en});
    if (fail && cfg_branch_en)
      chk(br_target == exp_target(ip, imm), {req, " R6 target"}, br_target, exp_target(ip, imm));
    chk(fault == (fail && !cfg_branch_en), {req, " R7 fault"}, {63'b0, fault},
        {63'b0, fail && !cfg_branch_en});
    if (fail && !cfg_branch_en)
      chk(fault_imm == {43'b0, imm}, {req, " R7 fault_imm"}, fault_imm, {43'b0, imm});
    chk(inv_valid == inv, {req, " R8 inv_valid"}, {63'b0, inv_valid}, {63'b0, inv});
    if (inv) begin
      chk(inv_fp == fp && inv_reg == rn, {req, " R8 inv key"}, {56'b0, inv_fp, inv_reg}, {56'b0, fp, rn});
      for (int i = 0; i < 8; i++) if (m_vld[i] && m_fp[i] == fp && m_reg[i] == rn) m_vld[i] = 0;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) begin m_vld[i] = 0; m_fp[i] = 0; m_reg[i] = '0; end
    repeat (3) @(negedge clk);
    chk(done == 0 && br_taken == 0 && fault == 0 && inv_valid == 0 && chk_fail == 0,
        "R13 reset outputs", {60'b0, done, br_taken, fault, inv_valid}, 64'd0);
    chk(br_target == 0 && fault_imm == 0, "R13 reset values", br_target | fault_imm, 64'd0);
    rst_n = 1;
    @(negedge clk);
    // R13: empty table, every data check fails
    do_op(1, 0, 7'd5, 0, 1, 0, 0, 64'h1000, 21'd3, "R13 empty table");
    // R1 / R2 control checks, ignoring the other flag
    do_op(0, 0, 7'd9, 0, 1, 1, 0, 64'h2007, 21'h1FFFFF, "R1 nat fail");
    do_op(0, 0, 7'd9, 0, 1, 0, 1, 64'h2000, 21'd4, "R1 natval ignored");
    do_op(0, 1, 7'd9, 0, 1, 0, 1, 64'h300F, 21'h100000, "R2 natval fail");
    do_op(0, 1, 7'd9, 0, 1, 1, 0, 64'h3000, 21'd4, "R2 nat ignored");
    // R3 hit / key mismatch
    do_ins(0, 7'd5);
    do_op(1, 0, 7'd5, 0, 1, 0, 0, 64'h4000, 21'd1, "R3 hit");
    do_op(1, 1, 7'd5, 0, 1, 0, 0, 64'h4000, 21'd1, "R3 file mismatch");
    // R4 hard-wired registers with entries present
    do_ins(0, 7'd0); do_ins(1, 7'd0); do_ins(1, 7'd1);
    do_op(1, 0, 7'd0, 1, 1, 0, 0, 64'h5000, 21'd2, "R4 gr0");
    do_op(1, 1, 7'd0, 1, 1, 0, 0, 64'h5000, 21'd2, "R4 fr0");
    do_op(1, 1, 7'd1, 1, 1, 0, 0, 64'h5000, 21'd2, "R4 fr1");
    // R7 fault path
    cfg_branch_en = 0;
    do_op(1, 0, 7'd33, 0, 1, 0, 0, 64'h6000, 21'h1ABCDE, "R7 fault");
    cfg_branch_en = 1;
    // R5 force fail, and its lack of effect on control mode; R9 no invalidation
    cfg_force_fail = 1;
    do_op(1, 0, 7'd5, 1, 1, 0, 0, 64'h7000, 21'd8, "R5 R9 forced fail clr");
    do_op(0, 0, 7'd5, 0, 1, 0, 0, 64'h7000, 21'd8, "R5 control unaffected");
    cfg_force_fail = 0;
    do_op(1, 0, 7'd5, 0, 1, 0, 0, 64'h7000, 21'd8, "R9 entry survives");
    // R10 qp=0 leaves the entry
    do_op(1, 0, 7'd5, 1, 0, 0, 0, 64'h7000, 21'd8, "R10 qp0 no effect");
    do_op(1, 0, 7'd5, 0, 1, 0, 0, 64'h7000, 21'd8, "R10 entry kept");
    do_op(0, 0, 7'd5, 0, 0, 1, 1, 64'h7000, 21'd8, "R10 qp0 control");
    // R8 clear then the entry is gone
    do_op(1, 0, 7'd5, 1, 1, 0, 0, 64'h8000, 21'd8, "R8 clear");
    do_op(1, 0, 7'd5, 0, 1, 0, 0, 64'h8000, 21'd8, "R8 gone");
    // R12 wrap: fill, then ninth insert displaces the oldest
    for (int i = 0; i < 8; i++) do_ins(1, 7'(20 + i));
    do_op(1, 1, 7'd20, 0, 1, 0, 0, 64'h9000, 21'd1, "R12 oldest present");
    do_ins(0, 7'd60);
    do_op(1, 1, 7'd20, 0, 1, 0, 0, 64'h9000, 21'd1, "R12 oldest replaced");
    do_op(1, 1, 7'd21, 0, 1, 0, 0, 64'h9000, 21'd1, "R12 next kept");
    // random mix
    for (int n = 0; n < 600; n++) begin
      if ($urandom_range(0, 9) < 3) do_ins(1'($urandom_range(0, 1)), 7'($urandom_range(0, 4)));
      cfg_branch_en  = ($urandom_range(0, 3) != 0);
      cfg_force_fail = ($urandom_range(0, 7) == 0);
      do_op(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 7'($urandom_range(0, 4)),
            1'($urandom_range(0, 1)), ($urandom_range(0, 7) != 0), 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)), {$urandom, $urandom}, 21'($urandom), "R3 R8 random");
    end
    @(negedge clk);
    chk(done == 0, "R11 single pulse", {63'b0, done}, 64'd0);
    finish_run();
  end
endmodule